// File: doc/BRIEF.md
# Two-Pipe Layer Compositor

This block merges four overlay layers into one RGB pixel stream, one pixel per clock. Every layer presents a coverage flag, a pipe select bit, a 2-bit priority, a flag saying whether its format carries alpha, and a 32-bit ARGB pixel. Composition happens in two steps. First, each of the two pipes keeps only its highest-priority covering layer, with no mixing inside a pipe. Second, the pipe 1 pixel is blended over the pipe 0 pixel, or over the background colour when pipe 0 is empty. The weight of that blend is the alpha of the pipe 1 pixel.

The background colour is held in a register that a write strobe loads, and it resets to black. A configuration error flag travels with each output pixel. It is raised when the layer set driven with that pixel cannot be blended correctly by this two-step structure. Pixel fields are packed as bits [31:24] alpha, [23:16] red, [15:8] green and [7:0] blue. Layer i occupies slice [32*i+31:32*i] of the pixel bus and slice [2*i+1:2*i] of the priority bus.

Top module: `layer_compositor`

## Requirements
- R1: Out of reset, outValid and cfgError are 0.
- R2: outValid equals inValid delayed by exactly two clock cycles, and each output pixel belongs to the input presented two cycles earlier.
- R3: Within one pipe, the covering layer with the numerically largest priority supplies that pipe's pixel unchanged; the other layers on that pipe have no effect.
- R4: When covering layers on one pipe tie on priority, the layer with the lower index wins.
- R5: When both pipes are covered, each channel of the output is (c1*a + c0*(255-a) + 127)/255 with integer division. Here c1 and c0 are the pipe 1 and pipe 0 channel values, and a is the 8-bit alpha of the pipe 1 winner. So a=255 gives c1 and a=0 gives c0.
- R6: A layer whose alpha flag is 0 is treated as fully opaque (a=255), whatever its alpha byte holds.
- R7: With pipe 1 empty, the output is the pipe 0 winner's RGB, or the background colour when no layer covers the pixel.
- R8: With pipe 0 empty and pipe 1 covered, the pipe 1 pixel is blended by R5 over the background colour.
- R9: The background colour resets to 0x000000. A bgWrEn pulse loads bgColorIn, and the new colour already applies to the pixel presented in the same cycle.
- R10: cfgError is 1 for an output pixel whose input had more than one covering layer with the alpha flag set.
- R11: cfgError is 1 for an output pixel whose input had a covering alpha layer on pipe 0, including the pipe 0, priority 0 slot.
- R12: Layers whose coverage flag is 0 have no effect on the output pixel or on cfgError, and cfgError is 0 whenever outValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input pixel strobe |
| layerCover | input | 4 | Per-layer coverage flag |
| layerPipe | input | 4 | Per-layer pipe select (0 or 1) |
| layerPrio | input | 8 | Per-layer 2-bit priority |
| layerHasAlpha | input | 4 | Per-layer flag: format carries alpha |
| layerPixel | input | 128 | Per-layer ARGB pixel |
| bgWrEn | input | 1 | Background colour load strobe |
| bgColorIn | input | 24 | New background RGB |
| outValid | output | 1 | Output pixel strobe |
| outPixel | output | 24 | Composited RGB pixel |
| cfgError | output | 1 | Illegal alpha configuration for this pixel |

## Verification
A wrong arbitration register shows up as an output pixel taken from the wrong layer. A wrong blend shows up as a channel that is off by as little as one code. In both cases the fault appears exactly two cycles after the offending input, so every vector is compared at that fixed offset. A stuck or misaligned valid or error stage shows up as outValid or cfgError tied to the wrong pixel. Background faults appear on the first uncovered pixel after reset or after a write. The random stream mixes coverage, pipe, priority and alpha patterns, and the directed vectors add ties, alpha extremes and illegal placements.

// File: rtl/comp_pkg.sv
package comp_pkg;
  parameter int NUM_LAYERS = 4;
  parameter int PRIO_W = 2;
  parameter int CH_W = 8;
  localparam int PIX_W = 4 * CH_W;
  localparam int RGB_W = 3 * CH_W;
  localparam int NUM_PIPES = 2;

  typedef struct packed {
    logic arbEn;
    logic blendEn;
  } strobe_t;

  typedef struct packed {
    logic hit;
    logic [CH_W-1:0] alpha;
    logic [RGB_W-1:0] rgb;
  } pipe_t;
endpackage

// File: rtl/comp_pipe_arb.sv
module comp_pipe_arb
  import comp_pkg::*;
#(
  parameter logic PIPE_ID = 1'b0
) (
  input  logic [NUM_LAYERS-1:0]        layerCover,
  input  logic [NUM_LAYERS-1:0]        layerPipe,
  input  logic [NUM_LAYERS*PRIO_W-1:0] layerPrio,
  input  logic [NUM_LAYERS-1:0]        layerHasAlpha,
  input  logic [NUM_LAYERS*PIX_W-1:0]  layerPixel,
  output pipe_t                        winner
);
  logic [PRIO_W-1:0] bestPrio;
  logic [PIX_W-1:0]  pix;

  always_comb begin
    winner = '0;
    bestPrio = '0;
    for (int i = 0; i < NUM_LAYERS; i++) begin
      pix = layerPixel[i*PIX_W +: PIX_W];
      if (layerCover[i] && (layerPipe[i] == PIPE_ID) &&
          (!winner.hit || (layerPrio[i*PRIO_W +: PRIO_W] > bestPrio))) begin
        winner.hit   = 1'b1;
        winner.rgb   = pix[RGB_W-1:0];
        winner.alpha = layerHasAlpha[i] ? pix[PIX_W-1:RGB_W] : {CH_W{1'b1}};
        bestPrio     = layerPrio[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/comp_blend.sv
module comp_blend
  import comp_pkg::*;
(
  input  pipe_t              topPipe,
  input  logic [RGB_W-1:0]   baseRgb,
  output logic [RGB_W-1:0]   blendRgb
);
  localparam int PROD_W = 2 * CH_W + 1;
  localparam logic [CH_W-1:0] FULL = {CH_W{1'b1}};

  logic [RGB_W-1:0] mixed;

  genvar c;
  generate
    for (c = 0; c < 3; c++) begin : g_ch
      logic [PROD_W-1:0] sumW;
      logic [PROD_W-1:0] quot;
      always_comb begin
        sumW = PROD_W'(topPipe.rgb[c*CH_W +: CH_W]) * PROD_W'(topPipe.alpha)
             + PROD_W'(baseRgb[c*CH_W +: CH_W]) * PROD_W'(FULL - topPipe.alpha)
             + PROD_W'(FULL >> 1);
        // exact floor(sumW / 255) over the reachable range
        quot = (sumW + PROD_W'(1) + (sumW >> CH_W)) >> CH_W;
        mixed[c*CH_W +: CH_W] = quot[CH_W-1:0];
      end
    end
  endgenerate

  assign blendRgb = topPipe.hit ? mixed : baseRgb;
endmodule

// File: rtl/comp_datapath.sv
module comp_datapath
  import comp_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strobe,
  input  logic [NUM_LAYERS-1:0]        layerCover,
  input  logic [NUM_LAYERS-1:0]        layerPipe,
  input  logic [NUM_LAYERS*PRIO_W-1:0] layerPrio,
  input  logic [NUM_LAYERS-1:0]        layerHasAlpha,
  input  logic [NUM_LAYERS*PIX_W-1:0]  layerPixel,
  input  logic [RGB_W-1:0]             bgColor,
  output logic [RGB_W-1:0]             outPixel
);
  pipe_t arbOut [NUM_PIPES];
  pipe_t pipeQ  [NUM_PIPES];
  logic [RGB_W-1:0] baseRgb;
  logic [RGB_W-1:0] blendRgb;
  logic unusedAlpha0;

  genvar p;
  generate
    for (p = 0; p < NUM_PIPES; p++) begin : g_pipe
      comp_pipe_arb #(.PIPE_ID(p[0])) u_arb (
        .layerCover(layerCover),
        .layerPipe(layerPipe),
        .layerPrio(layerPrio),
        .layerHasAlpha(layerHasAlpha),
        .layerPixel(layerPixel),
        .winner(arbOut[p])
      );
      always_ff @(posedge clk) begin
        if (!rstN) pipeQ[p] <= '0;
        else if (strobe.arbEn) pipeQ[p] <= arbOut[p];
      end
    end
  endgenerate

  assign unusedAlpha0 = ^pipeQ[0].alpha;
  assign baseRgb = pipeQ[0].hit ? pipeQ[0].rgb : bgColor;

  comp_blend u_blend (
    .topPipe(pipeQ[1]),
    .baseRgb(baseRgb),
    .blendRgb(blendRgb)
  );

  always_ff @(posedge clk) begin
    if (!rstN) outPixel <= '0;
    else if (strobe.blendEn) outPixel <= blendRgb;
  end
endmodule

// File: rtl/comp_ctrl.sv
module comp_ctrl
  import comp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [NUM_LAYERS-1:0] layerCover,
  input  logic [NUM_LAYERS-1:0] layerPipe,
  input  logic [NUM_LAYERS-1:0] layerHasAlpha,
  input  logic                  bgWrEn,
  input  logic [RGB_W-1:0]      bgColorIn,
  output strobe_t               strobe,
  output logic [RGB_W-1:0]      bgColor,
  output logic                  outValid,
  output logic                  cfgError
);
  localparam int CNT_W = $clog2(NUM_LAYERS + 1);

  logic [1:0] validQ;
  logic [1:0] errQ;
  logic [NUM_LAYERS-1:0] alphaAct;
  logic [CNT_W-1:0] alphaCnt;
  logic errNow;

  always_comb begin
    alphaAct = layerCover & layerHasAlpha;
    alphaCnt = '0;
    for (int i = 0; i < NUM_LAYERS; i++) alphaCnt = alphaCnt + CNT_W'(alphaAct[i]);
    errNow = (alphaCnt > CNT_W'(1)) || (|(alphaAct & ~layerPipe));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ  <= '0;
      errQ    <= '0;
      bgColor <= '0;
    end else begin
      validQ <= {validQ[0], inValid};
      errQ   <= {validQ[0] & errQ[0], inValid & errNow};
      if (bgWrEn) bgColor <= bgColorIn;
    end
  end

  assign strobe.arbEn   = inValid;
  assign strobe.blendEn = validQ[0];
  assign outValid = validQ[1];
  assign cfgError = errQ[1];
endmodule

// File: rtl/layer_compositor.sv
module layer_compositor
  import comp_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         inValid,
  input  logic [NUM_LAYERS-1:0]        layerCover,
  input  logic [NUM_LAYERS-1:0]        layerPipe,
  input  logic [NUM_LAYERS*PRIO_W-1:0] layerPrio,
  input  logic [NUM_LAYERS-1:0]        layerHasAlpha,
  input  logic [NUM_LAYERS*PIX_W-1:0]  layerPixel,
  input  logic                         bgWrEn,
  input  logic [RGB_W-1:0]             bgColorIn,
  output logic                         outValid,
  output logic [RGB_W-1:0]             outPixel,
  output logic                         cfgError
);
  strobe_t strobe;
  logic [RGB_W-1:0] bgColor;

  comp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .layerCover(layerCover), .layerPipe(layerPipe), .layerHasAlpha(layerHasAlpha),
    .bgWrEn(bgWrEn), .bgColorIn(bgColorIn),
    .strobe(strobe), .bgColor(bgColor), .outValid(outValid), .cfgError(cfgError)
  );

  comp_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .layerCover(layerCover), .layerPipe(layerPipe), .layerPrio(layerPrio),
    .layerHasAlpha(layerHasAlpha), .layerPixel(layerPixel),
    .bgColor(bgColor), .outPixel(outPixel)
  );
endmodule

// File: rtl/comp_checker.sv
module comp_checker
  import comp_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  inValid,
  input logic [NUM_LAYERS-1:0] layerCover,
  input logic [NUM_LAYERS-1:0] layerPipe,
  input logic [NUM_LAYERS-1:0] layerHasAlpha,
  input logic                  outValid,
  input logic [RGB_W-1:0]      outPixel,
  input logic                  cfgError,
  input logic [RGB_W-1:0]      bgColor
);
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid);  // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##2 !outValid);  // R2
  AST_BG_WHEN_BARE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && layerCover == '0) |=> ##1 (outPixel == $past(bgColor)));  // R7
  AST_MULTI_ALPHA_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && $countones(layerCover & layerHasAlpha) > 1) |-> ##2 cfgError);  // R10
  AST_PIPE0_ALPHA_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && |(layerCover & layerHasAlpha & ~layerPipe)) |-> ##2 cfgError);  // R11
  AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !cfgError);  // R12
endmodule

bind layer_compositor comp_checker u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .layerCover(layerCover),
  .layerPipe(layerPipe), .layerHasAlpha(layerHasAlpha), .outValid(outValid),
  .outPixel(outPixel), .cfgError(cfgError), .bgColor(bgColor)
);

// File: tb/tb_layer_compositor.sv
module tb_layer_compositor;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [3:0] layerCover = '0;
  logic [3:0] layerPipe = '0;
  logic [7:0] layerPrio = '0;
  logic [3:0] layerHasAlpha = '0;
  logic [127:0] layerPixel = '0;
  logic bgWrEn = 1'b0;
  logic [23:0] bgColorIn = '0;
  logic outValid;
  logic [23:0] outPixel;
  logic cfgError;

  int total = 0;
  int bad = 0;
  logic [23:0] modelBg = '0;
  logic aV = 1'b0, bV = 1'b0, aE = 1'b0, bE = 1'b0;
  logic [23:0] aP = '0, bP = '0;
  string aT = "R2", bT = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  layer_compositor dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .layerCover(layerCover),
    .layerPipe(layerPipe), .layerPrio(layerPrio), .layerHasAlpha(layerHasAlpha),
    .layerPixel(layerPixel), .bgWrEn(bgWrEn), .bgColorIn(bgColorIn),
    .outValid(outValid), .outPixel(outPixel), .cfgError(cfgError)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [24:0] model(input logic [3:0] cov, input logic [3:0] pip,
      input logic [7:0] pr, input logic [3:0] alf, input logic [127:0] pix, input logic [23:0] bg);
    logic err;
    logic hit [2];
    int best [2];
    int idx [2];
    logic [23:0] base, res;
    int a, c1, c0, n;
    n = 0;
    for (int i = 0; i < 4; i++) if (cov[i] && alf[i]) n++;
    err = (n > 1) || |(cov & alf & ~pip);
    for (int p = 0; p < 2; p++) begin
      hit[p] = 1'b0; best[p] = 0; idx[p] = 0;
      for (int i = 0; i < 4; i++)
        if (cov[i] && pip[i] == p[0] && (!hit[p] || int'(pr[2*i +: 2]) > best[p])) begin
          hit[p] = 1'b1; best[p] = int'(pr[2*i +: 2]); idx[p] = i;
        end
    end
    base = hit[0] ? pix[32*idx[0] +: 24] : bg;
    if (!hit[1]) res = base;
    else begin
      a = alf[idx[1]] ? int'(pix[32*idx[1]+24 +: 8]) : 255;
      for (int c = 0; c < 3; c++) begin
        c1 = int'(pix[32*idx[1]+8*c +: 8]);
        c0 = int'(base[8*c +: 8]);
        res[8*c +: 8] = 8'((c1*a + c0*(255-a) + 127) / 255);
      end
    end
    return {err, res};
  endfunction

  task automatic step(input logic v, input logic [3:0] cov, input logic [3:0] pip,
      input logic [7:0] pr, input logic [3:0] alf, input logic [127:0] pix,
      input logic wr, input logic [23:0] bgv, input string tag);
    logic [24:0] m;
    @(negedge clk);
    chk({aT, " valid"}, 32'(outValid), 32'(aV));
    chk({aT, " error"}, 32'(cfgError), 32'(aE));
    if (aV) chk({aT, " pixel"}, 32'(outPixel), 32'(aP));
    aV = bV; aE = bE; aP = bP; aT = bT;
    inValid = v; layerCover = cov; layerPipe = pip; layerPrio = pr;
    layerHasAlpha = alf; layerPixel = pix; bgWrEn = wr; bgColorIn = bgv;
    if (wr) modelBg = bgv;
    m = model(cov, pip, pr, alf, pix, modelBg);
    bV = v; bE = v & m[24]; bP = m[23:0]; bT = tag;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, '0, '0, '0, '0, '0, 1'b0, '0, "R2 idle");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [127:0] px;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset valid", 32'(outValid), 0);
    chk("R1 reset error", 32'(cfgError), 0);
    rstN = 1'b1;
    idle(2);
    // R9 reset background black, R7 bare pixel
    step(1'b1, 4'b0000, '0, '0, '0, {4{32'hFF_AA_BB_CC}}, 1'b0, '0, "R9 reset bg");
    step(1'b1, 4'b0000, '0, '0, '0, '0, 1'b1, 24'h123456, "R9 bg write");
    // R3 priority inside pipe 0
    px = {32'h00_444444, 32'h00_333333, 32'h00_222222, 32'h00_111111};
    step(1'b1, 4'b0011, 4'b0000, {2'd0, 2'd0, 2'd3, 2'd1}, '0, px, 1'b0, '0, "R3 prio");
    step(1'b1, 4'b1101, 4'b0000, {2'd2, 2'd3, 2'd0, 2'd1}, '0, px, 1'b0, '0, "R3 prio b");
    // R4 tie goes to lower index
    step(1'b1, 4'b0101, 4'b0000, {2'd0, 2'd2, 2'd0, 2'd2}, '0, px, 1'b0, '0, "R4 tie");
    step(1'b1, 4'b1100, 4'b1100, {2'd1, 2'd1, 2'd0, 2'd0}, '0, px, 1'b0, '0, "R4 tie p1");
    // R6 opaque pipe1 layer with junk alpha byte over pipe0
    px = {32'h00_000000, 32'h00_000000, 32'h10_ABCDEF, 32'h00_102030};
    step(1'b1, 4'b0011, 4'b0010, '0, 4'b0000, px, 1'b0, '0, "R6 opaque");
    // R5 alpha blend
    px = {32'h00_000000, 32'h00_000000, 32'h80_FF8040, 32'h00_0010F0};
    step(1'b1, 4'b0011, 4'b0010, '0, 4'b0010, px, 1'b0, '0, "R5 blend");
    px = {32'h00_000000, 32'h00_000000, 32'h00_FFFFFF, 32'h00_0010F0};
    step(1'b1, 4'b0011, 4'b0010, '0, 4'b0010, px, 1'b0, '0, "R5 alpha zero");
    px = {32'h00_000000, 32'h00_000000, 32'hFF_7F3311, 32'h00_0010F0};
    step(1'b1, 4'b0011, 4'b0010, '0, 4'b0010, px, 1'b0, '0, "R5 alpha full");
    // R8 pipe0 empty, blend over background
    px = {32'h40_C0C0C0, 32'h00_000000, 32'h00_000000, 32'h00_000000};
    step(1'b1, 4'b1000, 4'b1000, '0, 4'b1000, px, 1'b0, '0, "R8 over bg");
    // R7 pipe1 empty, pipe0 passes
    step(1'b1, 4'b0100, 4'b0000, '0, 4'b0000, {4{32'h77_5A5A5A}}, 1'b0, '0, "R7 pass");
    // R10 two alpha layers
    step(1'b1, 4'b1010, 4'b1010, '0, 4'b1010, {4{32'h80_808080}}, 1'b0, '0, "R10 two alpha");
    // R11 alpha on pipe 0 priority 0
    step(1'b1, 4'b0001, 4'b0000, '0, 4'b0001, {4{32'h80_808080}}, 1'b0, '0, "R11 p0 alpha");
    // R12 non-covering alpha layers ignored
    px = {32'h00_000000, 32'h20_999999, 32'h00_000000, 32'h55_0A0B0C};
    step(1'b1, 4'b0010, 4'b0110, 8'hFF, 4'b1101, px, 1'b0, '0, "R12 uncovered");
    step(1'b0, 4'b1111, 4'b0000, '0, 4'b1111, px, 1'b0, '0, "R12 no valid");
    idle(2);
    for (int k = 0; k < 3000; k++) begin
      px = {$urandom, $urandom, $urandom, $urandom};
      step(1'($urandom_range(0, 7) != 0), 4'($urandom), 4'($urandom), 8'($urandom),
           4'($urandom) & 4'($urandom), px, 1'($urandom_range(0, 31) == 0),
           24'($urandom), "R5 random");
    end
    idle(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule